// File: doc/BRIEF.md
# LPC Bus Transaction Monitor

A passive observer for a Low Pin Count bus. It samples the framing strobe (active low), the bus reset (active low) and the four multiplexed address/data lines on every rising clock edge. It follows each target cycle through its phases: start code, cycle kind, address, turn-around, wait/sync, data and closing turn-around. For every finished transaction it presents one registered record holding the start code, the cycle kind, the assembled address, the data byte and the final sync code, all qualified by a single-cycle valid pulse.

It covers I/O and memory reads and writes with one data byte. It never drives the bus. Protocol irregularities do not stop a cycle unless the cycle cannot be followed. These include a start code that changes while the strobe is held, a start code it does not follow, an unsupported or malformed cycle kind, a turn-around nibble other than all ones, and an unknown sync code. Each one raises a one-cycle warning pulse.

Top module: `lpc_txn_monitor`

## Requirements
- R1: While `frame_n` is low the monitor keeps the most recent `bus_nib` value. The start code recorded in `txn_start` is the value sampled on the last clock before `frame_n` returns high.
- R2: If `bus_nib` differs from the value sampled on the previous clock while `frame_n` stays low, `warn_lad_chg` pulses.
- R3: Only start code 0000 opens a tracked cycle. Start code 1111 returns the monitor to idle silently. Any other start code returns it to idle with a `warn_start` pulse, and no record is produced.
- R4: The nibble sampled on the first clock with `frame_n` high is the cycle kind. Bits [3:2] are 00 for I/O and 01 for memory, and bit 1 is 1 for a write. A kind with bit 3 set or bit 0 set pulses `warn_type`, sends the monitor to idle and produces no record.
- R5: I/O cycles carry 4 address nibbles and memory cycles carry 8, most significant nibble first. For I/O cycles the upper 16 bits of `txn_addr` are zero.
- R6: The data byte arrives as two nibbles, low nibble first.
- R7: A write runs address, data, turn-around, sync, turn-around. A read runs address, turn-around, sync, data, turn-around.
- R8: Each turn-around lasts 2 clocks. A sampled nibble other than 1111 in either clock pulses `warn_tar`, and the cycle continues.
- R9: Sync codes 0101 and 0110 are wait states that keep the monitor in the sync phase. Any other code ends the phase and is reported in `txn_sync`. 1010 also sets `txn_sync_err`. Codes other than 0000, 0101, 0110 and 1010 pulse `warn_sync`.
- R10: `txn_valid` is high for exactly one clock, in the cycle after the edge that samples the second closing turn-around nibble. The record fields are valid in that cycle.
- R11: `frame_n` sampled low after the start phase aborts the cycle. The monitor returns to idle and the partial transaction produces no record.
- R12: `bus_reset_n` sampled low returns the monitor to idle and discards any partial transaction.
- R13: Synchronous `rst` clears the state, the record and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the monitor |
| bus_reset_n | input | 1 | Bus reset, active low |
| frame_n | input | 1 | Cycle framing strobe, active low |
| bus_nib | input | 4 | Multiplexed address/data/control nibble |
| txn_valid | output | 1 | One-cycle pulse: record fields hold a finished transaction |
| txn_start | output | 4 | Start code of the transaction |
| txn_kind | output | 4 | Cycle kind/direction nibble |
| txn_addr | output | 32 | Assembled address (16 significant bits for I/O) |
| txn_data | output | 8 | Data byte |
| txn_sync | output | 4 | Sync code that ended the wait phase |
| txn_sync_err | output | 1 | Sync ended with the error code 1010 |
| warn_lad_chg | output | 1 | Start nibble changed while the strobe was held |
| warn_start | output | 1 | Start code not followed (other than 0000 and 1111) |
| warn_type | output | 1 | Unsupported or malformed cycle kind |
| warn_tar | output | 1 | Turn-around nibble was not 1111 |
| warn_sync | output | 1 | Unknown sync code |

## Verification
Every output is a register loaded at the edge that samples the causing nibble. A warning is therefore due in the cycle directly after the edge that samples the offending nibble. The record and `txn_valid` are due in the cycle after the edge that samples the second closing turn-around nibble. The bench keeps an edge counter and stores each expectation under the number of the edge that produces it. It compares all outputs 2 ns after every rising edge, so any early, late or missing pulse shows up as a mismatch in a specific cycle. Aborts, bus resets and rejected start codes or kinds are checked the same way, as cycles in which no record and no unexpected warning may appear.

// File: rtl/lpc_mon_pkg.sv
package lpc_mon_pkg;

  localparam int NIB_W  = 4;
  localparam int ADDR_W = 32;

  localparam logic [NIB_W-1:0] ST_TARGET = 4'b0000;
  localparam logic [NIB_W-1:0] ST_STOP   = 4'b1111;
  localparam logic [NIB_W-1:0] TAR_NIB   = 4'b1111;
  localparam logic [NIB_W-1:0] SY_READY  = 4'b0000;
  localparam logic [NIB_W-1:0] SY_SHORT  = 4'b0101;
  localparam logic [NIB_W-1:0] SY_LONG   = 4'b0110;
  localparam logic [NIB_W-1:0] SY_ERROR  = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_TAR1, PH_SYNC, PH_DATA, PH_TAR2
  } phase_t;

  typedef struct packed {
    logic lad_chg;
    logic start;
    logic kind;
    logic tar;
    logic sync;
  } warn_t;

  typedef struct packed {
    logic [NIB_W-1:0]  start;
    logic [NIB_W-1:0]  kind;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
    logic [NIB_W-1:0]  sync;
  } rec_t;

  function automatic logic sync_is_wait(input logic [NIB_W-1:0] c);
    return (c == SY_SHORT) || (c == SY_LONG);
  endfunction

  function automatic logic sync_is_known(input logic [NIB_W-1:0] c);
    return (c == SY_READY) || (c == SY_ERROR) || sync_is_wait(c);
  endfunction

endpackage

// File: rtl/lpc_phase_fsm.sv
module lpc_phase_fsm
  import lpc_mon_pkg::*;
#(
  parameter int IO_NIBS  = 4,
  parameter int MEM_NIBS = 8,
  parameter int TAR_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  input  logic [NIB_W-1:0] start_q,
  input  logic             kind_mem,
  input  logic             kind_write,
  output phase_t           phase,
  output logic             ld_start,
  output logic             ld_kind,
  output logic             sh_addr,
  output logic             ld_dlo,
  output logic             ld_dhi,
  output logic             ld_sync,
  output logic             done,
  output warn_t            warn
);

  localparam int CNT_MAX = (MEM_NIBS > TAR_CLKS) ? MEM_NIBS : TAR_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] IO_LAST  = CNT_W'(IO_NIBS - 1);
  localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_NIBS - 1);
  localparam logic [CNT_W-1:0] TAR_LAST = CNT_W'(TAR_CLKS - 1);

  phase_t           phase_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] addr_last;
  logic             in_body;

  assign addr_last = kind_mem ? MEM_LAST : IO_LAST;
  assign in_body   = (phase != PH_IDLE) && (phase != PH_START);

  always_comb begin
    phase_n  = phase;
    cnt_n    = cnt;
    ld_start = 1'b0;
    ld_kind  = 1'b0;
    sh_addr  = 1'b0;
    ld_dlo   = 1'b0;
    ld_dhi   = 1'b0;
    ld_sync  = 1'b0;
    done     = 1'b0;
    warn     = '0;
    if (!bus_reset_n) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
    end else if (!frame_n && in_body) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (!frame_n) begin
            ld_start = 1'b1;
            phase_n  = PH_START;
          end
        end
        PH_START: begin
          if (!frame_n) begin
            warn.lad_chg = (nib != start_q);
            ld_start     = 1'b1;
          end else if (start_q == ST_TARGET) begin
            if (nib[3] || nib[0]) begin
              warn.kind = 1'b1;
              phase_n   = PH_IDLE;
            end else begin
              ld_kind = 1'b1;
              cnt_n   = '0;
              phase_n = PH_ADDR;
            end
          end else begin
            warn.start = (start_q != ST_STOP);
            phase_n    = PH_IDLE;
          end
        end
        PH_ADDR: begin
          sh_addr = 1'b1;
          if (cnt == addr_last) begin
            cnt_n   = '0;
            phase_n = kind_write ? PH_DATA : PH_TAR1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (cnt == '0) begin
            ld_dlo = 1'b1;
            cnt_n  = CNT_W'(1);
          end else begin
            ld_dhi  = 1'b1;
            cnt_n   = '0;
            phase_n = kind_write ? PH_TAR1 : PH_TAR2;
          end
        end
        PH_TAR1, PH_TAR2: begin
          warn.tar = (nib != TAR_NIB);
          if (cnt == TAR_LAST) begin
            cnt_n = '0;
            if (phase == PH_TAR1) begin
              phase_n = PH_SYNC;
            end else begin
              done    = 1'b1;
              phase_n = PH_IDLE;
            end
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_SYNC: begin
          ld_sync = 1'b1;
          if (!sync_is_wait(nib)) begin
            warn.sync = !sync_is_known(nib);
            cnt_n     = '0;
            phase_n   = kind_write ? PH_TAR2 : PH_DATA;
          end
        end
        default: begin
          phase_n = PH_IDLE;
          cnt_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/lpc_field_capture.sv
module lpc_field_capture
  import lpc_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib,
  input  logic             ld_start,
  input  logic             ld_kind,
  input  logic             sh_addr,
  input  logic             ld_dlo,
  input  logic             ld_dhi,
  input  logic             ld_sync,
  output rec_t             fields
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= '0;
    end else begin
      if (ld_start) fields.start <= nib;
      if (ld_kind) begin
        fields.kind <= nib;
        fields.addr <= '0;
      end
      if (sh_addr) fields.addr <= {fields.addr[ADDR_W-NIB_W-1:0], nib};
      if (ld_dlo)  fields.data[3:0] <= nib;
      if (ld_dhi)  fields.data[7:4] <= nib;
      if (ld_sync) fields.sync <= nib;
    end
  end

endmodule

// File: rtl/lpc_report_reg.sv
module lpc_report_reg
  import lpc_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  done,
  input  rec_t  fields,
  input  warn_t warn_in,
  output logic  valid,
  output rec_t  rec,
  output logic  sync_err,
  output warn_t warn_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      rec      <= '0;
      sync_err <= 1'b0;
      warn_out <= '0;
    end else begin
      valid    <= done;
      warn_out <= warn_in;
      if (done) begin
        rec      <= fields;
        sync_err <= (fields.sync == SY_ERROR);
      end
    end
  end

endmodule

// File: rtl/lpc_txn_monitor.sv
module lpc_txn_monitor
  import lpc_mon_pkg::*;
#(
  parameter int IO_NIBS  = 4,
  parameter int MEM_NIBS = 8,
  parameter int TAR_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_reset_n,
  input  logic        frame_n,
  input  logic [3:0]  bus_nib,
  output logic        txn_valid,
  output logic [3:0]  txn_start,
  output logic [3:0]  txn_kind,
  output logic [31:0] txn_addr,
  output logic [7:0]  txn_data,
  output logic [3:0]  txn_sync,
  output logic        txn_sync_err,
  output logic        warn_lad_chg,
  output logic        warn_start,
  output logic        warn_type,
  output logic        warn_tar,
  output logic        warn_sync
);

  phase_t phase;
  logic   ld_start, ld_kind, sh_addr, ld_dlo, ld_dhi, ld_sync, done;
  warn_t  warn_c, warn_r;
  rec_t   fields, rec;

  lpc_phase_fsm #(
    .IO_NIBS (IO_NIBS),
    .MEM_NIBS(MEM_NIBS),
    .TAR_CLKS(TAR_CLKS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bus_reset_n(bus_reset_n),
    .frame_n    (frame_n),
    .nib        (bus_nib),
    .start_q    (fields.start),
    .kind_mem   (fields.kind[2]),
    .kind_write (fields.kind[1]),
    .phase      (phase),
    .ld_start   (ld_start),
    .ld_kind    (ld_kind),
    .sh_addr    (sh_addr),
    .ld_dlo     (ld_dlo),
    .ld_dhi     (ld_dhi),
    .ld_sync    (ld_sync),
    .done       (done),
    .warn       (warn_c)
  );

  lpc_field_capture u_cap (
    .clk     (clk),
    .rst     (rst),
    .nib     (bus_nib),
    .ld_start(ld_start),
    .ld_kind (ld_kind),
    .sh_addr (sh_addr),
    .ld_dlo  (ld_dlo),
    .ld_dhi  (ld_dhi),
    .ld_sync (ld_sync),
    .fields  (fields)
  );

  lpc_report_reg u_rep (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .fields  (fields),
    .warn_in (warn_c),
    .valid   (txn_valid),
    .rec     (rec),
    .sync_err(txn_sync_err),
    .warn_out(warn_r)
  );

  assign txn_start    = rec.start;
  assign txn_kind     = rec.kind;
  assign txn_addr     = rec.addr;
  assign txn_data     = rec.data;
  assign txn_sync     = rec.sync;
  assign warn_lad_chg = warn_r.lad_chg;
  assign warn_start   = warn_r.start;
  assign warn_type    = warn_r.kind;
  assign warn_tar     = warn_r.tar;
  assign warn_sync    = warn_r.sync;

endmodule

// File: rtl/lpc_txn_monitor_chk.sv
module lpc_txn_monitor_chk
  import lpc_mon_pkg::*;
#(
  parameter int IO_NIBS = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_reset_n,
  input logic        frame_n,
  input logic [3:0]  bus_nib,
  input phase_t      phase,
  input logic        txn_valid,
  input logic [3:0]  txn_kind,
  input logic [31:0] txn_addr,
  input logic        warn_tar,
  input logic        warn_type
);

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> !txn_valid);

  // R10
  valid_after_tar_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> $past(phase) == PH_TAR2);

  // R5
  io_addr_width_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !txn_kind[2]) |-> ((txn_addr >> (4 * IO_NIBS)) == 32'd0));

  // R8
  tar_warn_chk: assert property (@(posedge clk) disable iff (rst)
    warn_tar |-> ($past(bus_nib) != 4'b1111 &&
                  ($past(phase) == PH_TAR1 || $past(phase) == PH_TAR2)));

  // R4
  type_idle_chk: assert property (@(posedge clk) disable iff (rst)
    warn_type |-> phase == PH_IDLE);

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_n && !frame_n && phase != PH_IDLE && phase != PH_START)
      |=> (phase == PH_IDLE && !txn_valid));

  // R12
  bus_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_reset_n |=> (phase == PH_IDLE && !txn_valid));

endmodule

bind lpc_txn_monitor lpc_txn_monitor_chk #(.IO_NIBS(IO_NIBS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_reset_n(bus_reset_n),
  .frame_n    (frame_n),
  .bus_nib    (bus_nib),
  .phase      (phase),
  .txn_valid  (txn_valid),
  .txn_kind   (txn_kind),
  .txn_addr   (txn_addr),
  .warn_tar   (warn_tar),
  .warn_type  (warn_type)
);

// File: tb/lpc_txn_monitor_tb.sv
module lpc_txn_monitor_tb;

  localparam logic [4:0] W_LAD   = 5'b10000;
  localparam logic [4:0] W_START = 5'b01000;
  localparam logic [4:0] W_TYPE  = 5'b00100;
  localparam logic [4:0] W_TAR   = 5'b00010;
  localparam logic [4:0] W_SYNC  = 5'b00001;

  typedef struct packed {
    logic [3:0]  st;
    logic [3:0]  kind;
    logic [31:0] addr;
    logic [7:0]  data;
    logic [3:0]  sync;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset_n = 1'b1;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_nib = 4'hF;
  logic        txn_valid, txn_sync_err;
  logic [3:0]  txn_start, txn_kind, txn_sync;
  logic [31:0] txn_addr;
  logic [7:0]  txn_data;
  logic        warn_lad_chg, warn_start, warn_type, warn_tar, warn_sync;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R13";
  exp_t       exp_txn[int];
  logic [4:0] exp_warn[int];

  always #5 clk = ~clk;

  lpc_txn_monitor u_dut (
    .clk(clk), .rst(rst), .bus_reset_n(bus_reset_n), .frame_n(frame_n),
    .bus_nib(bus_nib), .txn_valid(txn_valid), .txn_start(txn_start),
    .txn_kind(txn_kind), .txn_addr(txn_addr), .txn_data(txn_data),
    .txn_sync(txn_sync), .txn_sync_err(txn_sync_err),
    .warn_lad_chg(warn_lad_chg), .warn_start(warn_start),
    .warn_type(warn_type), .warn_tar(warn_tar), .warn_sync(warn_sync)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // Per-edge comparison against the expectations stored by the drivers.
  always begin
    @(posedge clk);
    cyc = cyc + 1;
    #2;
    begin
      logic [4:0] w_exp;
      logic [4:0] w_act;
      w_exp = exp_warn.exists(cyc) ? exp_warn[cyc] : 5'b0;
      w_act = {warn_lad_chg, warn_start, warn_type, warn_tar, warn_sync};
      chk({"R10 valid (", cur_req, ")"}, {31'd0, txn_valid}, {31'd0, exp_txn.exists(cyc)});
      chk("R2 lad change warning", {31'd0, w_act[4]}, {31'd0, w_exp[4]});
      chk("R3 start warning", {31'd0, w_act[3]}, {31'd0, w_exp[3]});
      chk("R4 kind warning", {31'd0, w_act[2]}, {31'd0, w_exp[2]});
      chk("R8 turn-around warning", {31'd0, w_act[1]}, {31'd0, w_exp[1]});
      chk("R9 sync warning", {31'd0, w_act[0]}, {31'd0, w_exp[0]});
      if (exp_txn.exists(cyc) && txn_valid) begin
        chk("R1 start code", {28'd0, txn_start}, {28'd0, exp_txn[cyc].st});
        chk("R4 kind", {28'd0, txn_kind}, {28'd0, exp_txn[cyc].kind});
        chk("R5 address", txn_addr, exp_txn[cyc].addr);
        chk("R6 data", {24'd0, txn_data}, {24'd0, exp_txn[cyc].data});
        chk("R9 sync code", {28'd0, txn_sync}, {28'd0, exp_txn[cyc].sync});
        chk("R9 sync error", {31'd0, txn_sync_err}, {31'd0, exp_txn[cyc].err});
      end
    end
  end

  task automatic drive(input logic f, input logic [3:0] n, input logic [4:0] w);
    @(negedge clk);
    frame_n = f;
    bus_nib = n;
    if (w != 5'b0) exp_warn[cyc + 1] = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 4'hF, 5'b0);
  endtask

  task automatic start_phase(input logic [3:0] code, input int hold);
    for (int i = 0; i < hold; i++) drive(1'b0, code, 5'b0);
  endtask

  // Kind through closing turn-around, ordered per R7.
  task automatic xfer(input logic [3:0] kind, input logic [31:0] addr,
                      input logic [7:0] data, input int waits,
                      input logic [3:0] sync_end, input logic [3:0] tar_first);
    int   nibs;
    logic wr;
    exp_t e;
    nibs = kind[2] ? 8 : 4;
    wr   = kind[1];
    drive(1'b1, kind, 5'b0);
    for (int i = nibs - 1; i >= 0; i--) drive(1'b1, addr[4*i +: 4], 5'b0);
    if (wr) begin
      drive(1'b1, data[3:0], 5'b0);
      drive(1'b1, data[7:4], 5'b0);
    end
    drive(1'b1, tar_first, (tar_first != 4'hF) ? W_TAR : 5'b0);
    drive(1'b1, 4'hF, 5'b0);
    for (int i = 0; i < waits; i++) drive(1'b1, (i % 2 == 1) ? 4'b0110 : 4'b0101, 5'b0);
    drive(1'b1, sync_end,
          (sync_end == 4'b0000 || sync_end == 4'b1010) ? 5'b0 : W_SYNC);
    if (!wr) begin
      drive(1'b1, data[3:0], 5'b0);
      drive(1'b1, data[7:4], 5'b0);
    end
    drive(1'b1, 4'hF, 5'b0);
    drive(1'b1, 4'hF, 5'b0);
    e.st   = 4'b0000;
    e.kind = kind;
    e.addr = (nibs == 4) ? (addr & 32'h0000_FFFF) : addr;
    e.data = data;
    e.sync = sync_end;
    e.err  = (sync_end == 4'b1010);
    exp_txn[cyc + 1] = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(3);   // R13: outputs stay cleared after reset

    cur_req = "R7";
    start_phase(4'b0000, 1);
    xfer(4'b0010, 32'h0000_1234, 8'hA5, 0, 4'b0000, 4'hF);   // I/O write
    idle(2);
    start_phase(4'b0000, 1);
    xfer(4'b0100, 32'hDEAD_BEEF, 8'h3C, 3, 4'b0000, 4'hF);   // memory read with waits
    idle(2);

    cur_req = "R1";   // R2: start nibble changes twice while the strobe is held
    drive(1'b0, 4'b0101, 5'b0);
    drive(1'b0, 4'b0011, W_LAD);
    drive(1'b0, 4'b0000, W_LAD);
    xfer(4'b0000, 32'hFFFF_8001, 8'h5A, 1, 4'b0000, 4'hF);   // I/O read, upper bits dropped
    idle(1);

    cur_req = "R8";
    start_phase(4'b0000, 2);
    xfer(4'b0110, 32'h0123_4567, 8'hE1, 0, 4'b0000, 4'b0111);
    idle(1);

    cur_req = "R9";
    start_phase(4'b0000, 1);
    xfer(4'b0000, 32'h0000_00F0, 8'h81, 2, 4'b1010, 4'hF);   // error sync
    start_phase(4'b0000, 1);
    xfer(4'b0110, 32'h8000_0000, 8'h00, 0, 4'b1001, 4'hF);   // unknown sync
    idle(1);

    cur_req = "R3";
    start_phase(4'b1111, 1);
    drive(1'b1, 4'b0010, 5'b0);
    idle(1);
    start_phase(4'b1101, 2);
    drive(1'b1, 4'b0100, W_START);
    idle(1);

    cur_req = "R4";
    start_phase(4'b0000, 1);
    drive(1'b1, 4'b1000, W_TYPE);
    idle(1);
    start_phase(4'b0000, 1);
    drive(1'b1, 4'b0101, W_TYPE);
    idle(2);

    cur_req = "R11";   // abort during the address phase
    start_phase(4'b0000, 1);
    drive(1'b1, 4'b0100, 5'b0);
    for (int i = 0; i < 3; i++) drive(1'b1, 4'h7, 5'b0);
    start_phase(4'b1111, 4);
    idle(2);
    start_phase(4'b0000, 1);
    xfer(4'b0010, 32'h0000_0C0D, 8'h77, 0, 4'b0000, 4'hF);
    idle(1);

    cur_req = "R12";   // bus reset during the sync phase
    start_phase(4'b0000, 1);
    drive(1'b1, 4'b0000, 5'b0);
    for (int i = 0; i < 4; i++) drive(1'b1, 4'h9, 5'b0);
    drive(1'b1, 4'hF, 5'b0);
    drive(1'b1, 4'hF, 5'b0);
    drive(1'b1, 4'b0101, 5'b0);
    drive(1'b1, 4'b0101, 5'b0);
    bus_reset_n = 1'b0;
    drive(1'b1, 4'b0000, 5'b0);
    bus_reset_n = 1'b0;
    @(negedge clk);
    bus_reset_n = 1'b1;
    idle(2);
    start_phase(4'b0000, 1);
    xfer(4'b0100, 32'h1357_9BDF, 8'hC3, 0, 4'b0000, 4'hF);
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule